// File: doc/BRIEF.md
# Real-Mode Low-Address Guard and Prefix Swapper

This block screens memory accesses made with real addresses, before they reach storage. On each request it takes a real address, an access kind, a low-address-protection enable and the current prefix base. It then decides three things. The first is whether the access is a store into one of the two protected 512-byte windows; such a store is refused. The second is whether the page holding the address touches those windows; if so, a hint tells the requester not to cache the translation. The third is which absolute page the real page maps to.

The absolute page comes from a two-way swap. Real page frames in the lowest 8 KB are moved up into the prefix area. Frames inside the prefix area are moved down into the lowest 8 KB. Every other frame passes through unchanged. The result is registered and appears one cycle after the request strobe, together with a result strobe. A requester can issue one request per cycle.

Access kind encoding on `req_kind`: 0 is read, 1 is store, 2 is instruction fetch, and 3 is treated as a read. Permission encoding on `rsp_perm`: bit 0 is read, bit 1 is write and bit 2 is execute.

Top module: `real_prot_prefix`

## Requirements
- R1: An address counts as protected-low when it lies in 0 to 511 or in 4096 to 4607, both ends included. Addresses 512 to 4095 and 4608 and above are not protected-low.
- R2: When `lap_en` is 1 and the page-aligned address (address with its low 12 bits cleared) is protected-low, `rsp_wr_inval` is 1 for every access kind. This is the case for any address below 0x2000. Otherwise `rsp_wr_inval` is 0.
- R3: A store (`req_kind`=1) whose exact address is protected-low, with `lap_en`=1, is refused. The result has `rsp_fault`=1, `rsp_exc_code`=0x04, `rsp_perm`=3'b000 and `rsp_abs_addr`=0.
- R4: Without a fault, `rsp_perm`=3'b111 (read, write, execute) and `rsp_exc_code`=0x00.
- R5: With `lap_en`=0, no access faults and `rsp_wr_inval` is 0, whatever the address.
- R6: A page-aligned real address below 0x2000 maps to that address plus `prefix_base`.
- R7: A page-aligned real address at or above `prefix_base` and below `prefix_base`+0x2000 maps to that address minus `prefix_base`.
- R8: Any other page-aligned address passes through unchanged. `rsp_abs_addr` always has its low 12 bits at zero.
- R9: When an address falls in both the low area and the prefix area (only possible for a base below 0x2000), the low-area rule of R6 wins.
- R10: `rsp_valid` is 1 in exactly the cycle after a cycle with `req_valid`=1. Reset clears `rsp_valid` and all result outputs.
- R11: Reads and fetches in a protected-low window never fault. They still raise the hint of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | ADDR_W | Real address |
| req_kind | input | 2 | Access kind: 0 read, 1 store, 2 fetch, 3 as read |
| lap_en | input | 1 | Low-address protection enable |
| prefix_base | input | ADDR_W | Prefix area base, 8 KB aligned |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_perm | output | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| rsp_wr_inval | output | 1 | Do-not-reuse hint for the page |
| rsp_fault | output | 1 | Protection fault |
| rsp_exc_code | output | 8 | 0x04 on a protection fault, else 0x00 |
| rsp_abs_addr | output | ADDR_W | Absolute page address, 0 on a fault |

## Verification
The bench goes after the edges of both protected windows (511/512, 4095/4096, 4607/4608):
- An off-by-one in the window test would refuse a legal store at 512 or at 4608, or accept an illegal one at 511 or at 4607.

It probes the prefix swap at base−1, at base, at the last byte of the area and at base+0x2000:
- A wrong bound there would fold a neighbouring page into low storage or leave a prefix page unmapped.

It separates the page-granular hint from the byte-exact fault with stores at 0x200 and 0xFFF. Those stores must raise the hint but not fault. A design that used one address test for both would either fault them or drop the hint.

It also overlaps the two ranges with a base below 0x2000. A design that tested the prefix area first would return the low page instead of the raised one.

// File: rtl/real_prot_prefix.sv
module real_prot_prefix #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int WIN_BYTES = 512,
  parameter int SPAN      = 8192,
  parameter int EXC_W     = 8,
  parameter logic [EXC_W-1:0] EXC_PROT = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  input  logic              lap_en,
  input  logic [ADDR_W-1:0] prefix_base,
  output logic              rsp_valid,
  output logic [2:0]        rsp_perm,
  output logic              rsp_wr_inval,
  output logic              rsp_fault,
  output logic [EXC_W-1:0]  rsp_exc_code,
  output logic [ADDR_W-1:0] rsp_abs_addr
);
  localparam logic [ADDR_W-1:0] WIN_END0 = ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WIN_BEG1 = ADDR_W'(1 << PAGE_BITS);
  localparam logic [ADDR_W-1:0] WIN_END1 = ADDR_W'((1 << PAGE_BITS) + WIN_BYTES);
  localparam logic [ADDR_W-1:0] SPAN_A   = ADDR_W'(SPAN);

  function automatic logic low_hit(input logic [ADDR_W-1:0] a);
    return (a < WIN_END0) || ((a >= WIN_BEG1) && (a < WIN_END1));
  endfunction

  logic [ADDR_W-1:0] page_a, pfx_end, abs_n;
  logic              hint_n, fault_n, in_pfx;

  assign page_a  = {req_addr[ADDR_W-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
  assign pfx_end = prefix_base + SPAN_A;
  assign in_pfx  = (page_a >= prefix_base) && (page_a < pfx_end);
  assign hint_n  = lap_en && low_hit(page_a);
  assign fault_n = lap_en && (req_kind == 2'd1) && low_hit(req_addr);
  assign abs_n   = (page_a < SPAN_A) ? page_a + prefix_base :
                   in_pfx            ? page_a - prefix_base : page_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_perm     <= '0;
      rsp_wr_inval <= 1'b0;
      rsp_fault    <= 1'b0;
      rsp_exc_code <= '0;
      rsp_abs_addr <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_wr_inval <= hint_n;
        rsp_fault    <= fault_n;
        rsp_perm     <= fault_n ? 3'b000 : 3'b111;
        rsp_exc_code <= fault_n ? EXC_PROT : '0;
        rsp_abs_addr <= fault_n ? '0 : abs_n;
      end
    end
  end

  // R10
  rsp_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R10
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  // R3
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> ($past(req_kind) == 2'd1 && $past(lap_en)));
  // R2
  fault_hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_wr_inval);
  // R5
  lap_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(lap_en)) |-> (!rsp_wr_inval && !rsp_fault));
  // R8
  page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_abs_addr[PAGE_BITS-1:0] == '0));
  // R4
  clean_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (rsp_perm == 3'b111 && rsp_exc_code == '0));
endmodule

// File: tb/real_prot_prefix_bench.sv
module real_prot_prefix_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        lap_en = 1'b0;
  logic [31:0] prefix_base = '0;
  logic        rsp_valid, rsp_wr_inval, rsp_fault;
  logic [2:0]  rsp_perm;
  logic [7:0]  rsp_exc_code;
  logic [31:0] rsp_abs_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  real_prot_prefix u_real_prot_prefix (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_kind(req_kind), .lap_en(lap_en), .prefix_base(prefix_base),
    .rsp_valid(rsp_valid), .rsp_perm(rsp_perm), .rsp_wr_inval(rsp_wr_inval),
    .rsp_fault(rsp_fault), .rsp_exc_code(rsp_exc_code), .rsp_abs_addr(rsp_abs_addr));

  typedef struct packed {
    logic [31:0] addr;
    logic [1:0]  kind;
    logic        lap;
    logic [31:0] base;
    logic        hint;
    logic        fault;
    logic [31:0] abs_a;
  } vec_t;

  localparam int NV = 20;
  localparam logic [31:0] PB = 32'h0004_0000;
  localparam vec_t VECS [NV] = '{
    // R1 R3: window edges under store
    '{32'h0000_01FF, 2'd1, 1'b1, PB, 1'b1, 1'b1, 32'h0},
    '{32'h0000_0200, 2'd1, 1'b1, PB, 1'b1, 1'b0, 32'h0004_0000},
    '{32'h0000_0FFF, 2'd1, 1'b1, PB, 1'b1, 1'b0, 32'h0004_0000},
    '{32'h0000_1000, 2'd1, 1'b1, PB, 1'b1, 1'b1, 32'h0},
    '{32'h0000_11FF, 2'd1, 1'b1, PB, 1'b1, 1'b1, 32'h0},
    '{32'h0000_1200, 2'd1, 1'b1, PB, 1'b1, 1'b0, 32'h0004_1000},
    '{32'h0000_0000, 2'd1, 1'b1, PB, 1'b1, 1'b1, 32'h0},
    // R11: read and fetch in window
    '{32'h0000_0010, 2'd0, 1'b1, PB, 1'b1, 1'b0, 32'h0004_0000},
    '{32'h0000_1010, 2'd2, 1'b1, PB, 1'b1, 1'b0, 32'h0004_1000},
    '{32'h0000_0010, 2'd3, 1'b1, PB, 1'b1, 1'b0, 32'h0004_0000},
    // R5: protection off
    '{32'h0000_0010, 2'd1, 1'b0, PB, 1'b0, 1'b0, 32'h0004_0000},
    // R2 R8: first page past the hinted pages
    '{32'h0000_2000, 2'd1, 1'b1, PB, 1'b0, 1'b0, 32'h0000_2000},
    '{32'h0000_1FFF, 2'd0, 1'b1, PB, 1'b1, 1'b0, 32'h0004_1000},
    // R7 R8: prefix edges at base-1, base, end-1, end
    '{32'h0003_FFFF, 2'd0, 1'b1, PB, 1'b0, 1'b0, 32'h0003_F000},
    '{32'h0004_0000, 2'd0, 1'b1, PB, 1'b0, 1'b0, 32'h0000_0000},
    '{32'h0004_0001, 2'd1, 1'b1, PB, 1'b0, 1'b0, 32'h0000_0000},
    '{32'h0004_1FFF, 2'd2, 1'b1, PB, 1'b0, 1'b0, 32'h0000_1000},
    '{32'h0004_2000, 2'd0, 1'b1, PB, 1'b0, 1'b0, 32'h0004_2000},
    // R9: overlapping ranges, low rule first
    '{32'h0000_1800, 2'd0, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_2000},
    '{32'h0000_0800, 2'd0, 1'b0, 32'h0000_1000, 1'b0, 1'b0, 32'h0000_1000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 reset valid", 32'(rsp_valid), 32'd0);
    chk("R10 reset perm", 32'(rsp_perm), 32'd0);
    chk("R10 reset abs", rsp_abs_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle valid", 32'(rsp_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      req_valid   = 1'b1;
      req_addr    = VECS[i].addr;
      req_kind    = VECS[i].kind;
      lap_en      = VECS[i].lap;
      prefix_base = VECS[i].base;
      @(negedge clk);
      chk($sformatf("R10 valid v%0d", i), 32'(rsp_valid), 32'd1);
      chk($sformatf("R2 hint v%0d", i), 32'(rsp_wr_inval), 32'(VECS[i].hint));
      chk($sformatf("R3 fault v%0d", i), 32'(rsp_fault), 32'(VECS[i].fault));
      chk($sformatf("R4 perm v%0d", i), 32'(rsp_perm), VECS[i].fault ? 32'd0 : 32'd7);
      chk($sformatf("R3 code v%0d", i), 32'(rsp_exc_code), VECS[i].fault ? 32'h04 : 32'h00);
      chk($sformatf("abs R6 R7 R8 v%0d", i), rsp_abs_addr, VECS[i].abs_a);
    end

    // R10: no request, no result strobe
    req_valid = 1'b0;
    req_addr  = 32'h0000_0001;
    req_kind  = 2'd1;
    lap_en    = 1'b1;
    @(negedge clk);
    chk("R10 drop valid", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R10 still idle", 32'(rsp_valid), 32'd0);

    // R10: reset mid-stream clears a pending result
    req_valid = 1'b1;
    @(negedge clk);
    chk("R3 pre-reset fault", 32'(rsp_fault), 32'd1);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 reset clears valid", 32'(rsp_valid), 32'd0);
    chk("R10 reset clears fault", 32'(rsp_fault), 32'd0);
    finish_run();
  end
endmodule